// File: doc/BRIEF.md
# Bulk Command Register Write Decoder

This block sits behind a byte-wide command transport and turns register-write commands into updates of an internal 8-bit register file that drives display timing logic. Bytes arrive one per cycle when `in_valid` is high; `in_last` marks the final byte of a transfer burst. Each command starts with a prefix byte `0xAF` followed by a command code. The register-write command (`0x20`) carries one index byte and one value byte. A copy command (`0x6A`) is recognised only so that its fixed seven-byte payload can be stepped over. Any other code sends the parser back to searching for a prefix.

Writing to a dedicated control index (`0xFF`) locks or unlocks the video registers. While locked, incoming writes land only in a shadow bank and the registers seen by the timing logic do not move. The unlock write copies the whole shadow bank into the active bank in one cycle, so a complete mode change takes effect at once. Besides the raw register vector, the block decodes the multi-byte fields whose byte order differs by field: display sizes are stored high byte first, the pixel clock is stored low byte first, and the two 24-bit frame base addresses are stored high byte first across three registers.

Top module: `bulk_regwr_decoder`

## Requirements
- R1: After reset every active register reads zero, the bank is unlocked, `disp_on_o` is 1, `pwr_down_o` is 0, and all decoded fields are zero.
- R2: The sequence `0xAF`, `0x20`, index, value with the bank unlocked sets active register `index` to `value`, visible on `regs_o[index*8 +: 8]` on the clock edge that takes the value byte.
- R3: Cycles with `in_valid` low between the bytes of a command have no effect on its decoding.
- R4: A command code after the prefix that is neither `0x20`, `0x6A` nor `0xAF` returns the parser to searching; the following bytes are not taken as index or value.
- R5: A `0xAF` byte in the command-code position is treated as a fresh prefix, so `0xAF 0xAF 0x20 idx val` performs the write.
- R6: Command `0x6A` is followed by exactly seven payload bytes that are ignored, even if they contain `0xAF 0x20`; the byte after the payload is searched for a prefix.
- R7: A byte taken with `in_last` high ends any command in progress: a stray prefix, or a write missing its value byte, is dropped and the next burst starts in search.
- R8: After a write of `0x00` to index `0xFF` (lock), writes to indices below 64 change only the shadow bank; `regs_o` does not change.
- R9: A write of `0xFF` to index `0xFF` (unlock) copies every shadow register into the active bank on the same clock edge and leaves the bank unlocked.
- R10: A write to index `0xFF` with any value other than `0x00` or `0xFF` has no effect, and a write to an index from 64 to 254 changes no register.
- R11: `hdisp_o` is `{reg[0x0F], reg[0x10]}` and `vdisp_o` is `{reg[0x17], reg[0x18]}` (high byte at the lower index).
- R12: `pixclk_o`, in units of 5 kHz, is `{reg[0x1C], reg[0x1B]}` (low byte at the lower index).
- R13: `base16_o` is `{reg[0x20], reg[0x21], reg[0x22]}` and `base8_o` is `{reg[0x26], reg[0x27], reg[0x28]}`.
- R14: Register `0x1F` selects the output state: `0x00` gives `disp_on_o`=1, `0x07` gives `pwr_down_o`=1, any other value drives both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A command byte is present on `in_byte` |
| in_byte | input | 8 | Command stream byte |
| in_last | input | 1 | This byte closes the current burst |
| regs_o | output | NUM_REGS*8 | Active register file, register i at bits i*8+7..i*8 |
| hdisp_o | output | 16 | Horizontal visible pixels |
| vdisp_o | output | 16 | Vertical visible lines |
| pixclk_o | output | 16 | Pixel clock in 5 kHz units |
| base16_o | output | 24 | Base address of the 16-bit pixel plane |
| base8_o | output | 24 | Base address of the 8-bit pixel plane |
| disp_on_o | output | 1 | Blank register holds the display-on code |
| pwr_down_o | output | 1 | Blank register holds the power-down code |

## Verification
A parser left in the wrong state shows up as a register write that lands at the wrong index, takes a payload byte as data, or never happens; each such fault is visible on `regs_o` one edge after the value byte would have been taken, so the bench reads the affected register right after every command. A lock flag that is wrong shows either as active registers moving during a locked sequence or as nothing changing on unlock; the bench reads the registers before the unlock value byte and right after it, so a non-atomic or missing copy is seen within one cycle. Wrong byte order in a decoded field shows as swapped bytes on the field outputs as soon as the register writes complete.

// File: rtl/bcrw_pkg.sv
package bcrw_pkg;

    typedef enum logic [2:0] {
        PS_HUNT = 3'd0,
        PS_CMD  = 3'd1,
        PS_IDX  = 3'd2,
        PS_VAL  = 3'd3,
        PS_SKIP = 3'd4
    } pstate_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] idx;
        logic [7:0] val;
    } regwr_t;

endpackage

// File: rtl/bcrw_parser.sv
module bcrw_parser
    import bcrw_pkg::*;
#(
    parameter logic [7:0] PREFIX   = 8'hAF,
    parameter logic [7:0] CMD_WR   = 8'h20,
    parameter logic [7:0] CMD_SKIP = 8'h6A,
    parameter int         SKIP_LEN = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_last,
    output regwr_t     wr_o
);
    localparam int CW = $clog2(SKIP_LEN + 1);
    localparam logic [CW-1:0] SKIP_INIT = CW'(SKIP_LEN);
    localparam logic [CW-1:0] ONE       = CW'(1);

    typedef struct packed {
        pstate_e       st;
        logic [7:0]    idx;
        logic [CW-1:0] cnt;
    } ps_t;

    ps_t    ps_d, ps_q;
    regwr_t wr_d;

    always_comb begin
        ps_d = ps_q;
        wr_d = '0;
        if (in_valid) begin
            case (ps_q.st)
                PS_HUNT: begin
                    if (in_byte == PREFIX) ps_d.st = PS_CMD;
                end
                PS_CMD: begin
                    if (in_byte == CMD_WR) begin
                        ps_d.st = PS_IDX;
                    end else if (in_byte == CMD_SKIP) begin
                        ps_d.st  = PS_SKIP;
                        ps_d.cnt = SKIP_INIT;
                    end else if (in_byte == PREFIX) begin
                        ps_d.st = PS_CMD;
                    end else begin
                        ps_d.st = PS_HUNT;
                    end
                end
                PS_IDX: begin
                    ps_d.idx = in_byte;
                    ps_d.st  = PS_VAL;
                end
                PS_VAL: begin
                    wr_d.vld = 1'b1;
                    wr_d.idx = ps_q.idx;
                    wr_d.val = in_byte;
                    ps_d.st  = PS_HUNT;
                end
                PS_SKIP: begin
                    ps_d.cnt = ps_q.cnt - ONE;
                    if (ps_q.cnt == ONE) ps_d.st = PS_HUNT;
                end
                default: ps_d.st = PS_HUNT;
            endcase
            if (in_last) ps_d.st = PS_HUNT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '{st: PS_HUNT, idx: '0, cnt: '0};
        end else begin
            ps_q <= ps_d;
        end
    end

    assign wr_o = wr_d;

    // R7: a burst end always leaves the parser searching for a prefix
    a_r7_last_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_last |=> ps_q.st == PS_HUNT);

    // R6: the skip counter never leaves its legal range while skipping
    a_r6_skip_range: assert property (@(posedge clk) disable iff (!rst_n)
        ps_q.st == PS_SKIP |-> (ps_q.cnt != '0) && (ps_q.cnt <= SKIP_INIT));

    // R3: idle beats keep the parser where it was
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ps_q.st) && !$past(wr_o.vld));

endmodule

// File: rtl/bcrw_bank.sv
module bcrw_bank
    import bcrw_pkg::*;
#(
    parameter int         NUM_REGS    = 64,
    parameter logic [7:0] LOCK_IDX    = 8'hFF,
    parameter logic [7:0] LOCK_CODE   = 8'h00,
    parameter logic [7:0] UNLOCK_CODE = 8'hFF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  regwr_t                    wr_i,
    output logic [NUM_REGS-1:0][7:0]  active_o
);
    localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [8:0] LIMIT = 9'(NUM_REGS);

    typedef struct packed {
        logic                     locked;
        logic [NUM_REGS-1:0][7:0] shadow;
        logic [NUM_REGS-1:0][7:0] active;
    } bk_t;

    bk_t  bk_d, bk_q;
    logic is_ctrl;
    logic in_range;

    assign is_ctrl  = wr_i.vld && (wr_i.idx == LOCK_IDX);
    assign in_range = wr_i.vld && !is_ctrl && ({1'b0, wr_i.idx} < LIMIT);

    always_comb begin
        bk_d = bk_q;
        if (is_ctrl) begin
            if (wr_i.val == LOCK_CODE) begin
                bk_d.locked = 1'b1;
            end else if (wr_i.val == UNLOCK_CODE) begin
                bk_d.locked = 1'b0;
                bk_d.active = bk_q.shadow;
            end
        end else if (in_range) begin
            bk_d.shadow[wr_i.idx[AW-1:0]] = wr_i.val;
            if (!bk_q.locked) bk_d.active[wr_i.idx[AW-1:0]] = wr_i.val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign active_o = bk_q.active;

    // R8: while locked, no data write moves the active bank
    a_r8_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bk_q.locked && wr_i.vld && !is_ctrl |=> $stable(bk_q.active));

    // R9: unlock makes the active bank equal the shadow in one edge
    a_r9_unlock_copy: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctrl && wr_i.val == UNLOCK_CODE |=> !bk_q.locked && bk_q.active == $past(bk_q.shadow));

    // R2: when unlocked the two banks never diverge
    a_r2_banks_coherent: assert property (@(posedge clk) disable iff (!rst_n)
        !bk_q.locked |-> bk_q.shadow == bk_q.active);

    // R10: other control codes change neither lock nor data
    a_r10_ctrl_other: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctrl && wr_i.val != LOCK_CODE && wr_i.val != UNLOCK_CODE
        |=> $stable(bk_q.locked) && $stable(bk_q.active) && $stable(bk_q.shadow));

endmodule

// File: rtl/bcrw_view.sv
module bcrw_view #(
    parameter int         NUM_REGS   = 64,
    parameter int         HDISP_IDX  = 8'h0F,
    parameter int         VDISP_IDX  = 8'h17,
    parameter int         PIXCLK_IDX = 8'h1B,
    parameter int         BLANK_IDX  = 8'h1F,
    parameter int         BASE16_IDX = 8'h20,
    parameter int         BASE8_IDX  = 8'h26,
    parameter logic [7:0] BLANK_ON   = 8'h00,
    parameter logic [7:0] BLANK_OFF  = 8'h07
) (
    input  logic [NUM_REGS-1:0][7:0] regs_i,
    output logic [15:0]              hdisp_o,
    output logic [15:0]              vdisp_o,
    output logic [15:0]              pixclk_o,
    output logic [23:0]              base16_o,
    output logic [23:0]              base8_o,
    output logic                     disp_on_o,
    output logic                     pwr_down_o
);
    logic unused_regs;
    assign unused_regs = ^regs_i;

    // big-endian pairs: high byte at the lower index
    assign hdisp_o  = {regs_i[HDISP_IDX], regs_i[HDISP_IDX + 1]};
    assign vdisp_o  = {regs_i[VDISP_IDX], regs_i[VDISP_IDX + 1]};
    // pixel clock pair is little-endian
    assign pixclk_o = {regs_i[PIXCLK_IDX + 1], regs_i[PIXCLK_IDX]};
    // 24-bit bases, high byte first
    assign base16_o = {regs_i[BASE16_IDX], regs_i[BASE16_IDX + 1], regs_i[BASE16_IDX + 2]};
    assign base8_o  = {regs_i[BASE8_IDX],  regs_i[BASE8_IDX + 1],  regs_i[BASE8_IDX + 2]};

    assign disp_on_o  = (regs_i[BLANK_IDX] == BLANK_ON);
    assign pwr_down_o = (regs_i[BLANK_IDX] == BLANK_OFF);

    // R14: the two state outputs never assert together
    always_comb begin
        a_r14_exclusive: assert (!(disp_on_o && pwr_down_o));
    end

endmodule

// File: rtl/bulk_regwr_decoder.sv
module bulk_regwr_decoder
    import bcrw_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int SKIP_LEN = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [7:0]              in_byte,
    input  logic                    in_last,
    output logic [NUM_REGS*8-1:0]   regs_o,
    output logic [15:0]             hdisp_o,
    output logic [15:0]             vdisp_o,
    output logic [15:0]             pixclk_o,
    output logic [23:0]             base16_o,
    output logic [23:0]             base8_o,
    output logic                    disp_on_o,
    output logic                    pwr_down_o
);
    regwr_t                    wr_q;
    logic [NUM_REGS-1:0][7:0]  active;

    bcrw_parser #(
        .PREFIX   (8'hAF),
        .CMD_WR   (8'h20),
        .CMD_SKIP (8'h6A),
        .SKIP_LEN (SKIP_LEN)
    ) u_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_last  (in_last),
        .wr_o     (wr_q)
    );

    bcrw_bank #(
        .NUM_REGS    (NUM_REGS),
        .LOCK_IDX    (8'hFF),
        .LOCK_CODE   (8'h00),
        .UNLOCK_CODE (8'hFF)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_q),
        .active_o (active)
    );

    bcrw_view #(
        .NUM_REGS (NUM_REGS)
    ) u_view (
        .regs_i     (active),
        .hdisp_o    (hdisp_o),
        .vdisp_o    (vdisp_o),
        .pixclk_o   (pixclk_o),
        .base16_o   (base16_o),
        .base8_o    (base8_o),
        .disp_on_o  (disp_on_o),
        .pwr_down_o (pwr_down_o)
    );

    assign regs_o = active;

    // R1: the register file comes out of reset cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> regs_o == '0);

endmodule

// File: tb/bulk_regwr_decoder_tb.sv
module bulk_regwr_decoder_tb;
    localparam int NR = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [7:0]      in_byte;
    logic            in_last;
    logic [NR*8-1:0] regs_o;
    logic [15:0]     hdisp_o, vdisp_o, pixclk_o;
    logic [23:0]     base16_o, base8_o;
    logic            disp_on_o, pwr_down_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    bulk_regwr_decoder #(.NUM_REGS(NR)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_last(in_last), .regs_o(regs_o), .hdisp_o(hdisp_o), .vdisp_o(vdisp_o),
        .pixclk_o(pixclk_o), .base16_o(base16_o), .base8_o(base8_o),
        .disp_on_o(disp_on_o), .pwr_down_o(pwr_down_o)
    );

    function automatic logic [7:0] rd(input int i);
        return regs_o[i*8 +: 8];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input logic l = 1'b0);
        in_valid = 1'b1;
        in_byte  = b;
        in_last  = l;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] val);
        put(8'hAF); put(8'h20); put(idx); put(val);
    endtask

    task automatic t_reset;
        chk("R1", "regs", 32'(regs_o == '0), 32'd1);
        chk("R1", "disp_on", 32'(disp_on_o), 32'd1);
        chk("R1", "pwr_down", 32'(pwr_down_o), 32'd0);
        chk("R1", "base16", 32'(base16_o), 32'd0);
        chk("R1", "pixclk", 32'(pixclk_o), 32'd0);
    endtask

    task automatic t_basic;
        wr(8'h05, 8'h3C);
        chk("R2", "reg5", 32'(rd(5)), 32'h3C);
        put(8'hAF); @(negedge clk); put(8'h20); repeat (3) @(negedge clk);
        put(8'h06); @(negedge clk); @(negedge clk);
        chk("R3", "reg6 before value", 32'(rd(6)), 32'h00);
        put(8'h99);
        chk("R3", "reg6 with gaps", 32'(rd(6)), 32'h99);
    endtask

    task automatic t_fields;
        wr(8'h0F, 8'h04); wr(8'h10, 8'h00);
        chk("R11", "hdisp", 32'(hdisp_o), 32'h0400);
        wr(8'h17, 8'h03); wr(8'h18, 8'h00);
        chk("R11", "vdisp", 32'(vdisp_o), 32'h0300);
        wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
        chk("R12", "pixclk", 32'(pixclk_o), 32'h1234);
        wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
        chk("R13", "base16", 32'(base16_o), 32'h123456);
        wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF);
        chk("R13", "base8", 32'(base8_o), 32'hABCDEF);
    endtask

    task automatic t_blank;
        wr(8'h1F, 8'h07);
        chk("R14", "pwr_down", 32'({disp_on_o, pwr_down_o}), 32'b01);
        wr(8'h1F, 8'h03);
        chk("R14", "other code", 32'({disp_on_o, pwr_down_o}), 32'b00);
        wr(8'h1F, 8'h00);
        chk("R14", "disp_on", 32'({disp_on_o, pwr_down_o}), 32'b10);
    endtask

    task automatic t_framing;
        put(8'hAF); put(8'h55); put(8'h07); put(8'h44);
        chk("R4", "unknown cmd no write", 32'(rd(7)), 32'h00);
        wr(8'h07, 8'h45);
        chk("R4", "recovered", 32'(rd(7)), 32'h45);
        put(8'hAF); put(8'hAF); put(8'h20); put(8'h08); put(8'h77);
        chk("R5", "double prefix", 32'(rd(8)), 32'h77);
        put(8'hAF); put(8'h6A);
        put(8'hAF); put(8'h20); put(8'h09); put(8'h11); put(8'h00); put(8'h00); put(8'h00);
        wr(8'h0A, 8'h22);
        chk("R6", "payload ignored", 32'(rd(9)), 32'h00);
        chk("R6", "after skip", 32'(rd(10)), 32'h22);
        put(8'hAF, 1'b1); @(negedge clk);
        put(8'h20); put(8'h0B); put(8'h5A);
        chk("R7", "stray prefix", 32'(rd(11)), 32'h00);
        put(8'hAF); put(8'h20); put(8'h0C, 1'b1); put(8'h5B);
        chk("R7", "truncated write", 32'(rd(12)), 32'h00);
        wr(8'h0C, 8'h5C);
        chk("R7", "next burst", 32'(rd(12)), 32'h5C);
    endtask

    task automatic t_lock;
        logic [NR*8-1:0] snap;
        wr(8'hFF, 8'h00);
        wr(8'h0D, 8'h81); wr(8'h0E, 8'h82);
        chk("R8", "reg13 held", 32'(rd(13)), 32'h00);
        chk("R8", "reg14 held", 32'(rd(14)), 32'h00);
        snap = regs_o;
        wr(8'hFF, 8'h55);
        chk("R10", "other ctrl code", 32'(regs_o == snap), 32'd1);
        put(8'hAF); put(8'h20); put(8'hFF);
        chk("R9", "before unlock", 32'({rd(13), rd(14)}), 32'h0000);
        put(8'hFF);
        chk("R9", "after unlock", 32'({rd(13), rd(14)}), 32'h8182);
        wr(8'h0D, 8'h90);
        chk("R9", "unlocked after", 32'(rd(13)), 32'h90);
        snap = regs_o;
        wr(8'h40, 8'hEE);
        chk("R10", "out of range", 32'(regs_o == snap), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_byte  = 8'h00;
        in_last  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_fields;
        t_blank;
        t_framing;
        t_lock;
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule